// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of one single-rank SDR SDRAM from reset until the memory can take normal traffic. Out of reset it keeps clock enable and the byte masks high and drives only no-operation cycles for a wait time given in microseconds. That wait is turned into a cycle count from a clock-frequency parameter. It then closes every bank with one precharge and waits out the precharge time. Next it runs a programmable number of auto-refresh commands, spaced by the refresh cycle time. Last, it writes the mode register with a word built from the burst length, burst type and CAS latency inputs.

After the mode-register recovery time the block raises a ready flag. A controller then takes over the pins. If the configuration inputs ask for a reserved setting, the block issues no mode register write. It raises a sticky error flag and never becomes ready. All delays are counted in clock cycles, and every output is a register.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is asserted, and in every cycle of the initial wait, the block holds CKE high and every DQM bit high. It drives no-operation, encoded on (cs_n, ras_n, cas_n, we_n) as 0111, with address and bank zero. Ready and error stay low. CKE and DQM stay high after the wait as well.
- R2: The initial wait lasts INIT_CYC = CLK_MHZ * INIT_US cycles. The precharge command appears in the INIT_CYC-th cycle after reset is released, and no other command comes before it.
- R3: Precharge-all is encoded 0010 with address bit 10 high, all other address bits zero, and bank zero.
- R4: The first auto-refresh appears exactly T_RP cycles after the precharge, with no-operation in every cycle between.
- R5: Exactly N_REF auto-refresh commands (encoding 0001, address and bank zero) are issued, each T_RC cycles after the one before, with no-operation between. N_REF below 8 is rejected at elaboration.
- R6: For a legal configuration, the mode register set command (encoding 0000) appears T_RC cycles after the last refresh. Its address carries the burst length code in bits 2..0, burst type in bit 3 (0 sequential, 1 interleaved), CAS latency code in bits 6..4, and zero in all higher bits. The bank is zero.
- R7: A configuration is legal when burst length is 000, 001, 010 or 011 with either type, or 111 (full page) with sequential type, and CAS latency is 010 or 011. Every other code is reserved.
- R8: For a reserved configuration, no mode register set is issued. The error flag rises in the cycle where that command would have appeared and stays high until reset. Ready never rises, and only no-operation follows.
- R9: Ready rises exactly T_RSC cycles after the mode register set and stays high until reset. Only no-operation is driven afterwards, and later changes on the configuration inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bl | input | 3 | Burst length code |
| cfg_bt | input | 1 | Burst type, 0 sequential, 1 interleaved |
| cfg_cl | input | 3 | CAS latency code |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | DQM_W | Byte data masks |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus |
| sd_ba | output | BA_W | Bank address |
| init_done | output | 1 | Device initialized and ready |
| cfg_err | output | 1 | Reserved configuration requested |

## Verification
The sequence is run with six configurations: three legal and three reserved. The legal ones are a plain sequential burst of 8 at latency 2, a full-page sequential burst at latency 3, and an interleaved single-beat burst at latency 3. They show that each field lands in its own mode-word bit positions and that full page is accepted only with sequential type. The reserved ones are full page with interleaved type, an unsupported CAS latency, and a reserved burst length code. Each reserved case must suppress the mode register write and raise the error flag, so together they show that every legality rule is enforced on its own. On every cycle the bench compares the pins against a schedule computed from the timing parameters. It also changes the configuration after ready to show that the change is ignored.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // Command encodings on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_WAIT,
        PH_PRE_GAP,
        PH_REF_GAP,
        PH_MRS_GAP,
        PH_READY,
        PH_FAULT
    } phase_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == lim);

endmodule

// File: rtl/sdram_mode_enc.sv
module sdram_mode_enc #(
    parameter int ADDR_W = 12
) (
    input  logic [2:0]        bl,
    input  logic              bt,
    input  logic [2:0]        cl,
    output logic [ADDR_W-1:0] word,
    output logic              legal
);

    logic bl_ok, cl_ok;

    always_comb begin
        word      = '0;
        word[2:0] = bl;
        word[3]   = bt;
        word[6:4] = cl;

        unique case (bl)
            3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
            3'b111:                         bl_ok = ~bt;  // full page: sequential only
            default:                        bl_ok = 1'b0;
        endcase

        cl_ok = (cl == 3'b010) || (cl == 3'b011);
        legal = bl_ok && cl_ok;
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq #(
    parameter int CLK_MHZ = 250,
    parameter int INIT_US = 200,
    parameter int T_RP    = 5,
    parameter int T_RC    = 16,
    parameter int T_RSC   = 2,
    parameter int N_REF   = 8,
    parameter int ADDR_W  = 12,
    parameter int BA_W    = 2,
    parameter int DQM_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_bl,
    input  logic              cfg_bt,
    input  logic [2:0]        cfg_cl,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done,
    output logic              cfg_err
);
    import sdram_init_pkg::*;

    localparam int INIT_CYC = CLK_MHZ * INIT_US;
    localparam int GAP_A    = (T_RP > T_RC) ? T_RP : T_RC;
    localparam int GAP_B    = (GAP_A > T_RSC) ? GAP_A : T_RSC;
    localparam int MAX_GAP  = (INIT_CYC > GAP_B) ? INIT_CYC : GAP_B;
    localparam int CNT_W    = $clog2(MAX_GAP + 1);
    localparam int REF_W    = $clog2(N_REF + 1);

    generate
        if (N_REF < 8 || ADDR_W < 11 || T_RP < 1 || T_RC < 1 || T_RSC < 1 || INIT_CYC < 1) begin : g_param_bad
            $error("sdram_pwrup_seq: illegal parameter set");
        end
    endgenerate

    typedef struct packed {
        phase_e             phase;
        sd_cmd_e            cmd;
        logic [ADDR_W-1:0]  addr;
        logic [BA_W-1:0]    ba;
        logic [REF_W-1:0]   refs;
        logic               done;
        logic               err;
        logic               cke;
        logic [DQM_W-1:0]   dqm;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_lim;
    logic             tmr_hit;
    logic [ADDR_W-1:0] mode_word;
    logic             mode_legal;

    sdram_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (tmr_lim),
        .hit   (tmr_hit)
    );

    sdram_mode_enc #(.ADDR_W(ADDR_W)) u_mode (
        .bl    (cfg_bl),
        .bt    (cfg_bt),
        .cl    (cfg_cl),
        .word  (mode_word),
        .legal (mode_legal)
    );

    // Interval that ends the current phase
    always_comb begin
        unique case (st_q.phase)
            PH_WAIT:    tmr_lim = CNT_W'(INIT_CYC - 1);
            PH_PRE_GAP: tmr_lim = CNT_W'(T_RP - 1);
            PH_REF_GAP: tmr_lim = CNT_W'(T_RC - 1);
            PH_MRS_GAP: tmr_lim = CNT_W'(T_RSC - 1);
            default:    tmr_lim = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.cmd  = CMD_NOP;
        st_d.addr = '0;
        st_d.ba   = '0;
        st_d.cke  = 1'b1;
        st_d.dqm  = '1;
        tmr_clr   = 1'b0;

        unique case (st_q.phase)
            PH_WAIT: begin
                if (tmr_hit) begin
                    st_d.cmd      = CMD_PRE;
                    st_d.addr[10] = 1'b1;
                    st_d.phase    = PH_PRE_GAP;
                    tmr_clr       = 1'b1;
                end
            end
            PH_PRE_GAP: begin
                if (tmr_hit) begin
                    st_d.cmd   = CMD_REF;
                    st_d.refs  = REF_W'(1);
                    st_d.phase = PH_REF_GAP;
                    tmr_clr    = 1'b1;
                end
            end
            PH_REF_GAP: begin
                if (tmr_hit) begin
                    tmr_clr = 1'b1;
                    if (st_q.refs < REF_W'(N_REF)) begin
                        st_d.cmd  = CMD_REF;
                        st_d.refs = st_q.refs + 1'b1;
                    end else if (mode_legal) begin
                        st_d.cmd   = CMD_MRS;
                        st_d.addr  = mode_word;
                        st_d.phase = PH_MRS_GAP;
                    end else begin
                        st_d.err   = 1'b1;
                        st_d.phase = PH_FAULT;
                    end
                end
            end
            PH_MRS_GAP: begin
                if (tmr_hit) begin
                    st_d.done  = 1'b1;
                    st_d.phase = PH_READY;
                    tmr_clr    = 1'b1;
                end
            end
            default: begin
                tmr_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_WAIT;
            st_q.cmd   <= CMD_NOP;
            st_q.addr  <= '0;
            st_q.ba    <= '0;
            st_q.refs  <= '0;
            st_q.done  <= 1'b0;
            st_q.err   <= 1'b0;
            st_q.cke   <= 1'b1;
            st_q.dqm   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = st_q.cmd;
    assign sd_addr   = st_q.addr;
    assign sd_ba     = st_q.ba;
    assign sd_cke    = st_q.cke;
    assign sd_dqm    = st_q.dqm;
    assign init_done = st_q.done;
    assign cfg_err   = st_q.err;

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
    parameter int CLK_MHZ = 250,
    parameter int INIT_US = 200,
    parameter int T_RP    = 5,
    parameter int T_RC    = 16,
    parameter int T_RSC   = 2,
    parameter int N_REF   = 8,
    parameter int ADDR_W  = 12,
    parameter int BA_W    = 2,
    parameter int DQM_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cmd,
    input logic [ADDR_W-1:0] addr,
    input logic [BA_W-1:0]   ba,
    input logic              cke,
    input logic [DQM_W-1:0]  dqm,
    input logic              done,
    input logic              err
);
    localparam int INIT_CYC = CLK_MHZ * INIT_US;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] PRE = 4'b0010;
    localparam logic [3:0] REF = 4'b0001;
    localparam logic [3:0] MRS = 4'b0000;

    logic [3:0] last_q;
    int         gap_q, refs_q, cyc_q;
    logic       word_ok;

    always_comb begin
        word_ok = ((addr[2:0] <= 3'd3) || (addr[2:0] == 3'd7 && !addr[3]))
               && ((addr[6:4] == 3'd2) || (addr[6:4] == 3'd3));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= NOP;
            gap_q  <= 0;
            refs_q <= 0;
            cyc_q  <= 0;
        end else begin
            if (cyc_q < 32'h3fff_ffff) cyc_q <= cyc_q + 1;
            if (cmd != NOP) begin
                last_q <= cmd;
                gap_q  <= 1;
            end else if (gap_q < 32'h3fff_ffff) begin
                gap_q <= gap_q + 1;
            end
            if (cmd == REF) refs_q <= refs_q + 1;
        end
    end

    // R1
    cke_dqm_high_chk: assert property (@(posedge clk) disable iff (!rst_n) cke && (&dqm));
    // R1
    wait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < INIT_CYC) |-> (cmd == NOP && !done && !err));
    // R2
    pre_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == PRE) |-> (cyc_q == INIT_CYC));
    // R3
    pre_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == PRE) |-> (addr == (ADDR_W'(1) << 10) && ba == '0));
    // R4
    ref_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == REF && last_q == PRE) |-> (gap_q == T_RP));
    // R5
    ref_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == REF && last_q == REF) |-> (gap_q == T_RC));
    // R5
    ref_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == REF) |-> (refs_q < N_REF && addr == '0 && ba == '0));
    // R6
    mrs_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == MRS) |-> (last_q == REF && gap_q == T_RC && refs_q == N_REF
                          && ba == '0 && addr[ADDR_W-1:7] == '0));
    // R7
    mrs_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == MRS) |-> word_ok);
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);
    // R8
    err_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && cmd == NOP && last_q == REF));
    // R9
    ready_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (last_q == MRS && gap_q == T_RSC));
    // R9
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && cmd == NOP));

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
    .CLK_MHZ (CLK_MHZ),
    .INIT_US (INIT_US),
    .T_RP    (T_RP),
    .T_RC    (T_RC),
    .T_RSC   (T_RSC),
    .N_REF   (N_REF),
    .ADDR_W  (ADDR_W),
    .BA_W    (BA_W),
    .DQM_W   (DQM_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd   ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
    .addr  (sd_addr),
    .ba    (sd_ba),
    .cke   (sd_cke),
    .dqm   (sd_dqm),
    .done  (init_done),
    .err   (cfg_err)
);

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;

    localparam int CLK_MHZ  = 250;
    localparam int INIT_US  = 2;
    localparam int T_RP     = 4;
    localparam int T_RC     = 10;
    localparam int T_RSC    = 3;
    localparam int N_REF    = 9;
    localparam int ADDR_W   = 12;
    localparam int BA_W     = 2;
    localparam int DQM_W    = 2;
    localparam int INIT_CYC = CLK_MHZ * INIT_US;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        cfg_bl = '0;
    logic              cfg_bt = 1'b0;
    logic [2:0]        cfg_cl = '0;
    logic              sd_cke;
    logic [DQM_W-1:0]  sd_dqm;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [ADDR_W-1:0] sd_addr;
    logic [BA_W-1:0]   sd_ba;
    logic              init_done, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_RSC(T_RSC), .N_REF(N_REF), .ADDR_W(ADDR_W), .BA_W(BA_W), .DQM_W(DQM_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl), .cfg_bt(cfg_bt), .cfg_cl(cfg_cl),
        .sd_cke(sd_cke), .sd_dqm(sd_dqm), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba),
        .init_done(init_done), .cfg_err(cfg_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_case(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
        bit   legal;
        int   t_pre, t_mrs, t_done, t_end, first_ref;
        int   ref_times[$];
        logic [3:0]        e_cmd;
        logic [ADDR_W-1:0] e_addr;
        string             req;

        // R7: legality of the requested setting
        legal = ((bl <= 3'd3) || (bl == 3'd7 && !bt)) && (cl == 3'd2 || cl == 3'd3);
        t_pre     = INIT_CYC;
        first_ref = t_pre + T_RP;
        for (int i = 0; i < N_REF; i++) ref_times.push_back(first_ref + i * T_RC);
        t_mrs  = first_ref + N_REF * T_RC;
        t_done = t_mrs + T_RSC;
        t_end  = t_done + 12;

        @(negedge clk);
        rst_n  = 1'b0;
        cfg_bl = bl; cfg_bt = bt; cfg_cl = cl;
        repeat (3) @(negedge clk);
        // R1: state held during reset
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset cmd",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
        chk(sd_cke && (&sd_dqm) && !init_done && !cfg_err, "R1", "reset flags",
            {sd_cke, sd_dqm, init_done, cfg_err}, {1'b1, {DQM_W{1'b1}}, 2'b00});
        rst_n = 1'b1;

        for (int c = 1; c <= t_end; c++) begin
            @(negedge clk);
            e_cmd  = 4'b0111;
            e_addr = '0;
            req    = (c < t_pre) ? "R1" : ((c < first_ref) ? "R4" : "R5");
            if (c == t_pre) begin
                e_cmd = 4'b0010; e_addr[10] = 1'b1; req = "R2/R3";
            end else if (ref_times.size() > 0 && c == ref_times[0]) begin
                void'(ref_times.pop_front());
                e_cmd = 4'b0001;
                req   = (c == first_ref) ? "R4" : "R5";
            end else if (c == t_mrs) begin
                if (legal) begin
                    e_cmd = 4'b0000;
                    e_addr[2:0] = bl; e_addr[3] = bt; e_addr[6:4] = cl;
                    req = "R6";
                end else begin
                    req = "R8";
                end
            end else if (c > t_mrs) begin
                req = legal ? "R9" : "R8";
            end

            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == e_cmd, req, "cmd",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
            chk(sd_addr == e_addr && sd_ba == '0, req, "addr/ba",
                {sd_ba, sd_addr}, {{BA_W{1'b0}}, e_addr});
            chk(init_done == (legal && c >= t_done), "R9", "ready",
                init_done, (legal && c >= t_done));
            chk(cfg_err == (!legal && c >= t_mrs), "R8", "error",
                cfg_err, (!legal && c >= t_mrs));
            chk(sd_cke && (&sd_dqm), "R1", "cke/dqm", {sd_cke, sd_dqm}, {1'b1, {DQM_W{1'b1}}});

            // R9: configuration changed after ready must be ignored
            if (c == t_done + 2) begin
                cfg_bl = 3'd5; cfg_bt = 1'b1; cfg_cl = 3'd7;
            end
        end
    endtask

    initial begin
        run_case(3'd3, 1'b0, 3'd2);  // burst 8, sequential, CL2
        run_case(3'd7, 1'b0, 3'd3);  // full page, sequential, CL3
        run_case(3'd0, 1'b1, 3'd3);  // burst 1, interleaved, CL3
        run_case(3'd7, 1'b1, 3'd2);  // R7 reserved: full page interleaved
        run_case(3'd2, 1'b1, 3'd4);  // R7 reserved: CAS latency code
        run_case(3'd4, 1'b0, 3'd2);  // R7 reserved: burst length code
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule